// File: doc/BRIEF.md
# Dual-Chamber Pacing Timing Controller

This block is the timing core of a dual-chamber pacemaker that both senses and paces the atrium and the ventricle. It counts a one-millisecond tick and decides, tick by tick, whether an intrinsic beat has been seen or whether a pace pulse must be issued. Two elapsed-time counters drive the timing. One runs from the last ventricular event and the other from the last atrial event. Five programmable intervals are compared against them: the lower-rate escape, the atrioventricular delay, the upper-rate hold-off, the atrial blanking window after a ventricular event, and the ventricular refractory window.

The block works as a two-phase loop. In the atrial phase it waits for an accepted atrial sense or for the atrial escape deadline. In the AV phase it waits for an accepted ventricular sense or for the ventricular pace deadline. A host drives the interval inputs at any time. The block clamps the values and copies them into an active set only on ventricular events, so a beat in progress is never shortened. There is no data stream and so no valid/ready handshake. All pins are plain level or pulse signals, and sense inputs are sampled only in cycles where the tick is high.

Top module: `pm_ddd_timer`

## Requirements
- R1: After reset both pace outputs are low and the active intervals are lower rate 1000, AV 150, upper rate 500, atrial blanking 250 and ventricular refractory 150 ms. With no sensing, the first atrial pace therefore falls on tick 850 and the first ventricular pace falls on tick 1000.
- R2: In the atrial phase, an atrial pace is issued on the tick where the time since the last ventricular event reaches the lower rate minus the AV interval. If the AV interval is not smaller than the lower rate, this deadline is 1 tick.
- R3: In the AV phase, a ventricular pace is issued once the AV interval has elapsed since the atrial event, unless a ventricular sense is accepted first.
- R4: A ventricular pace is held until the upper-rate interval has also elapsed since the last ventricular event.
- R5: An atrial sense is accepted only in the atrial phase, and only when the time since the last ventricular event is at least the atrial blanking interval. The boundary tick is accepted. An accepted atrial sense suppresses the atrial pace and starts the AV phase. All other atrial senses are ignored.
- R6: A ventricular sense is accepted when the time since the last ventricular event is at least the ventricular refractory interval. It counts as a ventricular event, cancels any pending ventricular pace and returns the block to the atrial phase. A ventricular sense inside the refractory window is ignored.
- R7: Each programmed interval is clamped into the range 10 to 2500 ms before it is used.
- R8: Programmed intervals become active only on a ventricular event, and from that tick onward.
- R9: Each pace output is a one-cycle pulse in the cycle after the deciding tick, and the two pace outputs are never high together. Sense inputs in cycles without a tick have no effect.
- R10: When an accepted sense and the pace deadline of the same chamber fall on the same tick, the sense wins and no pace is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse marking each elapsed millisecond |
| a_sense_i | input | 1 | Atrial sense event, sampled on tick cycles |
| v_sense_i | input | 1 | Ventricular sense event, sampled on tick cycles |
| cfg_lri_i | input | 12 | Programmed lower-rate interval, ms |
| cfg_avi_i | input | 12 | Programmed AV delay, ms |
| cfg_uri_i | input | 12 | Programmed upper-rate interval, ms |
| cfg_pvarp_i | input | 12 | Programmed atrial blanking after ventricular events, ms |
| cfg_vrp_i | input | 12 | Programmed ventricular refractory interval, ms |
| a_pace_o | output | 1 | Atrial pace pulse |
| v_pace_o | output | 1 | Ventricular pace pulse |

## Verification
Every internal fault in this block appears as a pace pulse that lands on the wrong tick, a pulse that is missing, or a pulse that should not be there. A fault can be a wrong phase, a counter that restarts at the wrong moment, or a stale or unclamped interval. Each such fault shows within one beat of the stimulus that exposes it, so the expected pulse stream is written as exact tick numbers and compared pulse by pulse. The stimulus places senses exactly on window boundaries, on deadline ticks and between ticks, and it changes the intervals in the middle of a beat. This covers the cases where an off-by-one compare or an early parameter load would move a pulse by at least one tick.

// File: rtl/pm_ddd_pkg.sv
package pm_ddd_pkg;
  localparam int IVL_W   = 12;
  localparam int NUM_IVL = 5;

  // Slot of each interval in the packed interval vector
  localparam int IX_LRI   = 0;
  localparam int IX_AVI   = 1;
  localparam int IX_URI   = 2;
  localparam int IX_PVARP = 3;
  localparam int IX_VRP   = 4;

  typedef logic [IVL_W-1:0] ms_t;
  typedef logic [NUM_IVL-1:0][IVL_W-1:0] ivl_vec_t;

  typedef enum logic {PH_ATRIAL = 1'b0, PH_AV = 1'b1} phase_e;
endpackage

// File: rtl/pm_ms_timer.sv
// Saturating elapsed-millisecond counter; reports the value it will hold after this tick.
module pm_ms_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  output logic [W-1:0] elapsed_next
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  assign elapsed_next = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick)    cnt_q <= restart ? '0 : elapsed_next;
  end
endmodule

// File: rtl/pm_ivl_shadow.sv
// Clamps programmed intervals and copies them into the active set on load.
module pm_ivl_shadow
  import pm_ddd_pkg::*;
#(
  parameter ms_t      LO   = 12'd10,
  parameter ms_t      HI   = 12'd2500,
  parameter ivl_vec_t INIT = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  ivl_vec_t raw,
  output ivl_vec_t act
);
  ivl_vec_t clamped;

  for (genvar g = 0; g < NUM_IVL; g++) begin : g_clamp
    assign clamped[g] = (raw[g] < LO) ? LO :
                        (raw[g] > HI) ? HI : raw[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act <= INIT;
    else if (load)  act <= clamped;
  end
endmodule

// File: rtl/pm_ddd_arbiter.sv
// Phase machine: weighs accepted senses against escape and pace deadlines.
module pm_ddd_arbiter
  import pm_ddd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     a_sense,
  input  logic     v_sense,
  input  ivl_vec_t act,
  input  ms_t      a_el,
  input  ms_t      v_el,
  output logic     a_evt,
  output logic     v_evt,
  output logic     a_pace,
  output logic     v_pace
);
  phase_e phase_q, phase_d;
  ms_t    escape;
  logic   vs_ok, as_ok, a_due, v_due;

  // Atrial escape measured from the last ventricular event, floored at one tick
  assign escape = (act[IX_LRI] > act[IX_AVI]) ? ms_t'(act[IX_LRI] - act[IX_AVI]) : ms_t'(1);

  assign vs_ok = tick && v_sense && (v_el >= act[IX_VRP]);
  assign as_ok = tick && a_sense && (phase_q == PH_ATRIAL) && (v_el >= act[IX_PVARP]);
  assign a_due = tick && (phase_q == PH_ATRIAL) && (v_el >= escape);
  assign v_due = tick && (phase_q == PH_AV) && (a_el >= act[IX_AVI]) && (v_el >= act[IX_URI]);

  // Sense has priority over pace; a ventricular sense overrides atrial activity
  assign a_evt = !vs_ok && (as_ok || a_due);
  assign v_evt = vs_ok || v_due;

  always_comb begin
    phase_d = phase_q;
    if (vs_ok)       phase_d = PH_ATRIAL;
    else if (a_evt)  phase_d = PH_AV;
    else if (v_due)  phase_d = PH_ATRIAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ATRIAL;
      a_pace  <= 1'b0;
      v_pace  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      a_pace  <= a_due && !as_ok && !vs_ok;
      v_pace  <= v_due && !vs_ok;
    end
  end
endmodule

// File: rtl/pm_ddd_timer.sv
module pm_ddd_timer
  import pm_ddd_pkg::*;
#(
  parameter ms_t LO_MS     = 12'd10,
  parameter ms_t HI_MS     = 12'd2500,
  parameter ms_t DEF_LRI   = 12'd1000,
  parameter ms_t DEF_AVI   = 12'd150,
  parameter ms_t DEF_URI   = 12'd500,
  parameter ms_t DEF_PVARP = 12'd250,
  parameter ms_t DEF_VRP   = 12'd150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick_i,
  input  logic             a_sense_i,
  input  logic             v_sense_i,
  input  logic [IVL_W-1:0] cfg_lri_i,
  input  logic [IVL_W-1:0] cfg_avi_i,
  input  logic [IVL_W-1:0] cfg_uri_i,
  input  logic [IVL_W-1:0] cfg_pvarp_i,
  input  logic [IVL_W-1:0] cfg_vrp_i,
  output logic             a_pace_o,
  output logic             v_pace_o
);
  localparam int       NUM_TMR  = 2;
  localparam ivl_vec_t INIT_VEC = {DEF_VRP, DEF_PVARP, DEF_URI, DEF_AVI, DEF_LRI};

  ivl_vec_t                raw_cfg, act;
  logic                    a_evt, v_evt;
  logic [NUM_TMR-1:0]      tmr_restart;
  ms_t  [NUM_TMR-1:0]      tmr_el;

  assign raw_cfg     = {cfg_vrp_i, cfg_pvarp_i, cfg_uri_i, cfg_avi_i, cfg_lri_i};
  assign tmr_restart = {v_evt, a_evt};

  pm_ivl_shadow #(.LO(LO_MS), .HI(HI_MS), .INIT(INIT_VEC)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (v_evt),
    .raw   (raw_cfg),
    .act   (act)
  );

  // Timer 0 runs from atrial events, timer 1 from ventricular events
  for (genvar c = 0; c < NUM_TMR; c++) begin : g_tmr
    pm_ms_timer #(.W(IVL_W)) u_tmr (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (ms_tick_i),
      .restart      (tmr_restart[c]),
      .elapsed_next (tmr_el[c])
    );
  end

  pm_ddd_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ms_tick_i),
    .a_sense (a_sense_i),
    .v_sense (v_sense_i),
    .act     (act),
    .a_el    (tmr_el[0]),
    .v_el    (tmr_el[1]),
    .a_evt   (a_evt),
    .v_evt   (v_evt),
    .a_pace  (a_pace_o),
    .v_pace  (v_pace_o)
  );
endmodule

// File: rtl/pm_ddd_timer_chk.sv
module pm_ddd_timer_chk
  import pm_ddd_pkg::*;
#(
  parameter ms_t LO = 12'd10,
  parameter ms_t HI = 12'd2500
) (
  input logic     clk,
  input logic     rst_n,
  input logic     ms_tick,
  input logic     a_pace,
  input logic     v_pace,
  input logic     v_evt,
  input ivl_vec_t act
);
  assert_pace_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_pace && v_pace)) else $error("atrial and ventricular pace together");

  assert_ap_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    a_pace |=> !a_pace) else $error("atrial pace wider than one cycle");

  assert_vp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    v_pace |=> !v_pace) else $error("ventricular pace wider than one cycle");

  assert_pace_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pace || v_pace) |-> $past(ms_tick)) else $error("pace not preceded by a tick");

  assert_vp_is_vevent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v_pace |-> $past(v_evt)) else $error("ventricular pace without ventricular event");

  assert_ap_sense_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a_pace |-> !$past(v_evt)) else $error("atrial pace on a ventricular event tick");

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !v_evt |=> $stable(act)) else $error("active intervals changed off a ventricular event");

  for (genvar g = 0; g < NUM_IVL; g++) begin : g_rng
    assert_cfg_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act[g] >= LO) && (act[g] <= HI)) else $error("active interval out of range");
  end
endmodule

bind pm_ddd_timer pm_ddd_timer_chk #(.LO(LO_MS), .HI(HI_MS)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ms_tick (ms_tick_i),
  .a_pace  (a_pace_o),
  .v_pace  (v_pace_o),
  .v_evt   (v_evt),
  .act     (act)
);

// File: tb/pm_ddd_timer_tb_top.sv
`timescale 1ns/1ps
module pm_ddd_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic        a_sense = 1'b0;
  logic        v_sense = 1'b0;
  logic [11:0] cfg_lri = 12'd1000, cfg_avi = 12'd150, cfg_uri = 12'd500;
  logic [11:0] cfg_pvarp = 12'd250, cfg_vrp = 12'd150;
  logic        a_pace, v_pace;

  int compared = 0;
  int mismatched = 0;
  int tick_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    bit    is_v;
    int    t;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  pm_ddd_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick),
    .a_sense_i(a_sense), .v_sense_i(v_sense),
    .cfg_lri_i(cfg_lri), .cfg_avi_i(cfg_avi), .cfg_uri_i(cfg_uri),
    .cfg_pvarp_i(cfg_pvarp), .cfg_vrp_i(cfg_vrp),
    .a_pace_o(a_pace), .v_pace_o(v_pace)
  );

  task automatic push_exp(bit is_v, int t, string req);
    exp_t e;
    e.is_v = is_v; e.t = t; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic do_tick(bit as, bit vs);
    @(negedge clk);
    ms_tick = 1'b1; a_sense = as; v_sense = vs;
    tick_cnt++;
    @(negedge clk);
    ms_tick = 1'b0; a_sense = 1'b0; v_sense = 1'b0;
  endtask

  task automatic run_to(int t);
    while (tick_cnt < t) do_tick(1'b0, 1'b0);
  endtask

  task automatic sense_at(int t, bit as, bit vs);
    run_to(t - 1);
    do_tick(as, vs);
  endtask

  task automatic set_cfg(int lri, int avi, int uri, int pv, int vr);
    cfg_lri = 12'(lri); cfg_avi = 12'(avi); cfg_uri = 12'(uri);
    cfg_pvarp = 12'(pv); cfg_vrp = 12'(vr);
  endtask

  // Monitor: every pace pulse is matched against the next expected item
  always @(posedge clk) begin
    #1;
    if (rst_n && !done && (a_pace || v_pace)) begin
      compared++;
      if (a_pace && v_pace) begin
        mismatched++;
        $display("FAIL R9: both paces high at tick %0d (actual 2 pulses, expected 1)", tick_cnt);
      end else if (sb_q.size() == 0) begin
        mismatched++;
        $display("FAIL R2/R3: unexpected %s pace at tick %0d (expected none)",
                 v_pace ? "V" : "A", tick_cnt);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.is_v != v_pace || e.t != tick_cnt) begin
          mismatched++;
          $display("FAIL %s: actual %s pace at tick %0d, expected %s pace at tick %0d",
                   e.req, v_pace ? "V" : "A", tick_cnt, e.is_v ? "V" : "A", e.t);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual tick %0d, expected run to end by tick 8250", tick_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Expected pace stream, in tick order
    push_exp(0,  850, "R1");  push_exp(1, 1000, "R1");
    push_exp(0, 1850, "R8");  push_exp(1, 2000, "R3");
    push_exp(0, 2070, "R2");  push_exp(1, 2100, "R3");
    push_exp(0, 2170, "R2");  push_exp(1, 2200, "R3");
    push_exp(1, 2290, "R5");                          // accepted atrial sense at 2260
    push_exp(0, 2360, "R2");  push_exp(1, 2390, "R3");
    push_exp(0, 2460, "R9");  push_exp(1, 2490, "R5"); // blanked and off-tick senses ignored
    push_exp(1, 2570, "R4");                          // upper-rate hold after boundary sense
    push_exp(0, 2640, "R2");                          // VP cancelled by sense at 2660
    push_exp(0, 2730, "R6");  push_exp(1, 2760, "R6");
    push_exp(0, 2830, "R6");  push_exp(1, 2860, "R6");
    push_exp(0, 2960, "R6");  push_exp(1, 2990, "R6"); // premature ventricular sense at 2890
    push_exp(0, 3060, "R8");  push_exp(1, 3090, "R8");
    push_exp(0, 3091, "R2");  push_exp(1, 5591, "R7"); // floor escape, AV clamped to 2500
    push_exp(0, 8081, "R7");  push_exp(1, 8091, "R7"); // lower rate clamped to 2500, AV to 10
    push_exp(1, 8191, "R10");                         // sense on escape tick, no atrial pace

    repeat (4) @(negedge clk);
    compared++;
    if (a_pace !== 1'b0 || v_pace !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: paces in reset actual %b%b, expected 00", a_pace, v_pace);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compared++;
    if (a_pace !== 1'b0 || v_pace !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: paces after reset actual %b%b, expected 00", a_pace, v_pace);
    end

    run_to(1500);
    set_cfg(100, 30, 80, 40, 20);          // R8: loads at ventricular event 2000
    sense_at(2260, 1'b1, 1'b0);            // R5 accepted
    sense_at(2420, 1'b1, 1'b0);            // R5 inside blanking, ignored
    run_to(2445);
    @(negedge clk); a_sense = 1'b1;        // R9 sense without tick, ignored
    @(negedge clk); a_sense = 1'b0;
    sense_at(2530, 1'b1, 1'b0);            // R5 boundary accepted, R4 hold
    sense_at(2660, 1'b0, 1'b1);            // R6 cancels pending VP
    sense_at(2770, 1'b0, 1'b1);            // R6 inside refractory, ignored
    sense_at(2890, 1'b0, 1'b1);            // R6 accepted in atrial phase
    run_to(3000);
    set_cfg(5, 3000, 10, 10, 10);          // R7 clamps, loads at 3090
    run_to(4000);
    set_cfg(4000, 5, 10, 10, 10);          // R7 clamps, loads at 5591
    run_to(6000);
    set_cfg(100, 30, 80, 40, 20);          // loads at 8091
    sense_at(8161, 1'b1, 1'b0);            // R10 sense on escape tick
    run_to(8250);
    repeat (4) @(negedge clk);

    done = 1'b1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      compared++;
      mismatched++;
      $display("FAIL %s: actual no pulse, expected %s pace at tick %0d",
               e.req, e.is_v ? "V" : "A", e.t);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule